// File: doc/BRIEF.md
# Consecutive-Match Threshold Comparator

The block watches the conversion results of a multi-channel converter as they are written into result storage. For one selected channel it tests each result against a 12-bit threshold, using either a "below" or an "at or above" condition. Results can be read as unsigned or as two's-complement numbers.

A counter tracks how many qualifying samples in a row have met the condition. A sample that misses the condition clears the counter. Once the run reaches the programmed length plus one, a sticky flag is raised. The flag requests an interrupt when interrupts are enabled, and it stays set until a clear pulse removes it. To get two independent watchers, instantiate the block twice with its configuration and result inputs shared.

Top module: `thresh_run_cmp`

## Requirements
- R1: After synchronous reset, `cmp_flag` and `cmp_irq` are 0, the run counter is 0 and the stored configuration word is 0, so the block is disabled.
- R2: A sample is qualified only when all three of these hold in the same cycle: `res_load` is 1, the enable bit (bit 0) is 1, and `res_chan` equals the channel select (bits 6:3). A sample on another channel, or any sample while disabled, leaves the run counter unchanged.
- R3: When the condition bit (bit 2) is 0, a sample matches if the result is strictly less than the threshold (bits 27:16). When the condition bit is 1, a sample matches if the result is greater than or equal to the threshold.
- R4: When `fmt_signed` is 1, both the result and the threshold are compared as 12-bit two's-complement values. When `fmt_signed` is 0, both are compared as unsigned values.
- R5: Let N be the match count in bits 11:8. The qualified matching sample that brings the run counter to N+1 sets `cmp_flag` in the cycle after its load.
- R6: A qualified sample that does not match clears the run counter to 0.
- R7: `cmp_flag` stays set until `flag_clr` is pulsed. If a flag-setting sample arrives in the same cycle as `flag_clr`, the set wins.
- R8: `cmp_irq` is 1 exactly when `cmp_flag` is 1 and the interrupt enable bit (bit 1) is 1.
- R9: Once the run counter reaches N+1 it saturates there. Each further qualified match sets the flag again.
- R10: A configuration write clears the run counter. A sample loaded in the same cycle as the write is discarded. While the enable bit is 0, the counter is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word (fields as in R2, R3, R5, R8) |
| fmt_signed | input | 1 | 1 = two's-complement results and threshold |
| res_load | input | 1 | A conversion result is being stored this cycle |
| res_chan | input | 4 | Channel of the stored result |
| res_data | input | 12 | Value of the stored result |
| flag_clr | input | 1 | Write-one pulse that clears the flag |
| cmp_flag | output | 1 | Sticky compare flag |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
The run counter is internal, so a wrong count shows at the ports only later. It appears as a flag that rises one sample too early or too late, or never rises, on the sample that should complete a run. A missed clear from a configuration write, a non-matching sample or the disabled state shows up the same way. The bench finds such faults by ending each run exactly one sample short and then one sample on. A wrong comparison, a wrong number format or a wrong set-versus-clear priority shows directly on `cmp_flag` one cycle after the load in question.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int DATA_W = 12;
    localparam int CH_W   = 4;
    localparam int MC_W   = 4;
    localparam int WORD_W = 32;

    localparam int THR_LSB = 16;
    localparam int MC_LSB  = 8;
    localparam int CH_LSB  = 3;
    localparam int GE_BIT  = 2;
    localparam int IE_BIT  = 1;
    localparam int EN_BIT  = 0;

    typedef struct packed {
        logic [DATA_W-1:0] thr;
        logic [MC_W-1:0]   run_len;
        logic [CH_W-1:0]   chan;
        logic              ge_mode;
        logic              irq_en;
        logic              enable;
    } cmp_cfg_t;

    typedef struct packed {
        logic qualified;
        logic meets;
    } verdict_t;

    function automatic cmp_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
        cmp_cfg_t c;
        c.thr     = w[THR_LSB +: DATA_W];
        c.run_len = w[MC_LSB +: MC_W];
        c.chan    = w[CH_LSB +: CH_W];
        c.ge_mode = w[GE_BIT];
        c.irq_en  = w[IE_BIT];
        c.enable  = w[EN_BIT];
        return c;
    endfunction

    function automatic logic sample_meets(input logic [DATA_W-1:0] value,
                                          input logic [DATA_W-1:0] thr,
                                          input logic              ge_mode,
                                          input logic              as_signed);
        logic below;
        if (as_signed)
            below = $signed(value) < $signed(thr);
        else
            below = value < thr;
        return ge_mode ? !below : below;
    endfunction

endpackage

// File: rtl/trc_cfg_reg.sv
module trc_cfg_reg
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output cmp_cfg_t          cfg
);
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else if (wr)
            word_q <= wdata;
    end

    assign cfg = unpack_cfg(word_q);

    logic unused_word_bits;
    assign unused_word_bits = ^{word_q[WORD_W-1:THR_LSB+DATA_W],
                                word_q[THR_LSB-1:MC_LSB+MC_W],
                                word_q[MC_LSB-1:CH_LSB+CH_W]};
endmodule

// File: rtl/trc_matcher.sv
module trc_matcher
    import trc_pkg::*;
(
    input  cmp_cfg_t          cfg,
    input  logic              cfg_wr,
    input  logic              fmt_signed,
    input  logic              res_load,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [DATA_W-1:0] res_data,
    output verdict_t          verdict
);
    always_comb begin
        verdict.qualified = res_load && cfg.enable && !cfg_wr && (res_chan == cfg.chan);
        verdict.meets     = sample_meets(res_data, cfg.thr, cfg.ge_mode, fmt_signed);
    end
endmodule

// File: rtl/trc_run_ctr.sv
module trc_run_ctr
    import trc_pkg::*;
#(
    parameter int RUN_W = MC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             enable,
    input  logic [RUN_W-1:0] run_len,
    input  verdict_t         verdict,
    input  logic             flag_clr,
    output logic             flag
);
    localparam int CNT_W = RUN_W + 1;

    logic [CNT_W-1:0] cnt, cnt_nxt, limit;
    logic             set_now;

    assign limit = {1'b0, run_len} + CNT_W'(1);

    always_comb begin
        cnt_nxt = cnt;
        set_now = 1'b0;
        if (cfg_wr || !enable) begin
            cnt_nxt = '0;
        end else if (verdict.qualified) begin
            if (verdict.meets) begin
                cnt_nxt = (cnt >= limit) ? limit : cnt + CNT_W'(1);
                set_now = (cnt_nxt == limit);
            end else begin
                cnt_nxt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            cnt  <= cnt_nxt;
            flag <= set_now || (flag && !flag_clr);
        end
    end

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit) else $error("counter above limit"); // R9

    AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(verdict.qualified && verdict.meets)) else $error("flag rose without hit"); // R5

    AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (verdict.qualified && !verdict.meets) |=> (cnt == '0)) else $error("miss kept count"); // R6

    AST_CFG_RESETS: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr || !enable) |=> (cnt == '0)) else $error("count survived write"); // R10

    AST_IGNORED_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!verdict.qualified && enable && !cfg_wr) |=> $stable(cnt)) else $error("unqualified sample moved count"); // R2

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !(verdict.qualified && verdict.meets)) |=> !flag) else $error("clear ignored"); // R7
endmodule

// File: rtl/thresh_run_cmp.sv
module thresh_run_cmp
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              fmt_signed,
    input  logic              res_load,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [DATA_W-1:0] res_data,
    input  logic              flag_clr,
    output logic              cmp_flag,
    output logic              cmp_irq
);
    cmp_cfg_t cfg;
    verdict_t verdict;

    trc_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    trc_matcher u_match (
        .cfg        (cfg),
        .cfg_wr     (cfg_wr),
        .fmt_signed (fmt_signed),
        .res_load   (res_load),
        .res_chan   (res_chan),
        .res_data   (res_data),
        .verdict    (verdict)
    );

    trc_run_ctr #(.RUN_W(MC_W)) u_run (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .enable   (cfg.enable),
        .run_len  (cfg.run_len),
        .verdict  (verdict),
        .flag_clr (flag_clr),
        .flag     (cmp_flag)
    );

    assign cmp_irq = cmp_flag && cfg.irq_en;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        cmp_irq |-> cmp_flag) else $error("irq without flag"); // R8
endmodule

// File: tb/thresh_run_cmp_test.sv
module thresh_run_cmp_test;

    typedef struct packed {
        logic        wr;
        logic [31:0] cfg;
        logic        fmt;
        logic        ld;
        logic [3:0]  ch;
        logic [11:0] d;
        logic        clr;
        logic        ef;
        logic        ei;
        logic [3:0]  req;
    } vec_t;

    // cfg fields: thr[27:16] mc[11:8] ch[6:3] ge[2] ie[1] en[0]
    localparam logic [31:0] CA = 32'h0100_021B; // thr 0x100 mc2 ch3 below ie en
    localparam logic [31:0] CB = 32'h0800_005D; // thr 0x800 mc0 ch11 ge en
    localparam logic [31:0] CC = 32'h0000_0103; // thr 0 mc1 ch0 below ie en
    localparam logic [31:0] CD = 32'h0000_0102; // CC disabled

    localparam int NV = 41;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, CA, 1'b0, 1'b0, 4'd0,  12'h000, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 write
        '{1'b0, CA, 1'b0, 1'b1, 4'd3,  12'h050, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 cnt1
        '{1'b0, CA, 1'b0, 1'b1, 4'd3,  12'h0FF, 1'b0, 1'b0, 1'b0, 4'd3},  // cnt2
        '{1'b0, CA, 1'b0, 1'b1, 4'd5,  12'hFFF, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 other channel
        '{1'b0, CA, 1'b0, 1'b1, 4'd3,  12'h000, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 cnt3
        '{1'b0, CA, 1'b0, 1'b0, 4'd3,  12'h000, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 clear
        '{1'b0, CA, 1'b0, 1'b1, 4'd3,  12'h010, 1'b0, 1'b1, 1'b1, 4'd9},  // R9 saturated
        '{1'b0, CA, 1'b0, 1'b1, 4'd3,  12'h010, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 set wins
        '{1'b0, CA, 1'b0, 1'b0, 4'd3,  12'h000, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b0, CA, 1'b0, 1'b1, 4'd3,  12'h100, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 equal misses
        '{1'b0, CA, 1'b0, 1'b1, 4'd3,  12'h001, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, CA, 1'b0, 1'b1, 4'd3,  12'h002, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, CA, 1'b0, 1'b1, 4'd3,  12'h200, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 miss
        '{1'b0, CA, 1'b0, 1'b1, 4'd3,  12'h003, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, CA, 1'b0, 1'b1, 4'd3,  12'h004, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, CA, 1'b0, 1'b1, 4'd3,  12'h005, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 run restarted
        '{1'b1, CB, 1'b0, 1'b0, 4'd0,  12'h000, 1'b1, 1'b0, 1'b0, 4'd10},
        '{1'b0, CB, 1'b0, 1'b1, 4'd11, 12'h7FF, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 unsigned
        '{1'b0, CB, 1'b0, 1'b1, 4'd11, 12'h800, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 ie off, R3 equal
        '{1'b0, CB, 1'b0, 1'b0, 4'd0,  12'h000, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b0, CB, 1'b1, 1'b1, 4'd11, 12'h7FF, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 signed
        '{1'b0, CB, 1'b0, 1'b0, 4'd0,  12'h000, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b0, CB, 1'b0, 1'b1, 4'd11, 12'h7FF, 1'b0, 1'b0, 1'b0, 4'd4},
        '{1'b1, CC, 1'b0, 1'b0, 4'd0,  12'h000, 1'b0, 1'b0, 1'b0, 4'd10},
        '{1'b0, CC, 1'b1, 1'b1, 4'd0,  12'hFFF, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 -1 < 0
        '{1'b0, CC, 1'b1, 1'b1, 4'd0,  12'hFFF, 1'b0, 1'b1, 1'b1, 4'd4},
        '{1'b0, CC, 1'b0, 1'b0, 4'd0,  12'h000, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, CC, 1'b0, 1'b0, 4'd0,  12'h000, 1'b0, 1'b0, 1'b0, 4'd10},
        '{1'b0, CC, 1'b1, 1'b1, 4'd0,  12'hFFF, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 reset by write
        '{1'b0, CC, 1'b1, 1'b1, 4'd0,  12'hFFF, 1'b0, 1'b1, 1'b1, 4'd5},
        '{1'b0, CC, 1'b0, 1'b0, 4'd0,  12'h000, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, CD, 1'b0, 1'b0, 4'd0,  12'h000, 1'b0, 1'b0, 1'b0, 4'd10},
        '{1'b0, CD, 1'b1, 1'b1, 4'd0,  12'hFFF, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 disabled
        '{1'b0, CD, 1'b1, 1'b1, 4'd0,  12'hFFF, 1'b0, 1'b0, 1'b0, 4'd2},
        '{1'b1, CC, 1'b0, 1'b0, 4'd0,  12'h000, 1'b0, 1'b0, 1'b0, 4'd10},
        '{1'b0, CC, 1'b1, 1'b1, 4'd0,  12'hFFF, 1'b0, 1'b0, 1'b0, 4'd10},
        '{1'b0, CC, 1'b1, 1'b1, 4'd0,  12'hFFF, 1'b0, 1'b1, 1'b1, 4'd5},
        '{1'b0, CC, 1'b0, 1'b0, 4'd0,  12'h000, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, CC, 1'b1, 1'b1, 4'd0,  12'hFFF, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 discard on write
        '{1'b0, CC, 1'b1, 1'b1, 4'd0,  12'hFFF, 1'b0, 1'b0, 1'b0, 4'd10},
        '{1'b0, CC, 1'b1, 1'b1, 4'd0,  12'hFFF, 1'b0, 1'b1, 1'b1, 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [31:0] cfg_wdata;
    logic        fmt_signed;
    logic        res_load;
    logic [3:0]  res_chan;
    logic [11:0] res_data;
    logic        flag_clr;
    logic        cmp_flag;
    logic        cmp_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    thresh_run_cmp uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .fmt_signed(fmt_signed), .res_load(res_load), .res_chan(res_chan),
        .res_data(res_data), .flag_clr(flag_clr), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
    );

    task automatic check(input logic ef, input logic ei, input int req, input string tag);
        checks++;
        if (cmp_flag !== ef || cmp_irq !== ei) begin
            fails++;
            $display("FAIL R%0d %s: flag/irq actual %b%b expected %b%b", req, tag, cmp_flag, cmp_irq, ef, ei);
        end
    endtask

    task automatic idle_inputs();
        cfg_wr = 1'b0; cfg_wdata = '0; fmt_signed = 1'b0;
        res_load = 1'b0; res_chan = '0; res_data = '0; flag_clr = 1'b0;
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        cfg_wr = v.wr; cfg_wdata = v.cfg; fmt_signed = v.fmt;
        res_load = v.ld; res_chan = v.ch; res_data = v.d; flag_clr = v.clr;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check(1'b0, 1'b0, 1, "reset state R1");
        @(negedge clk);
        rst = 1'b0;
        // disabled after reset: matching-looking samples on channel 0 do nothing
        apply('{1'b0, 32'h0, 1'b0, 1'b1, 4'd0, 12'h000, 1'b0, 1'b0, 1'b0, 4'd1});
        check(1'b0, 1'b0, 1, "config cleared by reset R1");

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check(VECS[i].ef, VECS[i].ei, int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // mid-run reset clears flag and counter (R1)
        apply('{1'b0, CC, 1'b1, 1'b0, 4'd0, 12'h000, 1'b1, 1'b0, 1'b0, 4'd7});
        apply('{1'b0, CC, 1'b1, 1'b1, 4'd0, 12'hFFF, 1'b0, 1'b1, 1'b1, 4'd9});
        check(1'b1, 1'b1, 9, "saturated before reset R9");
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(posedge clk);
        #2;
        check(1'b0, 1'b0, 1, "flag dropped by reset R1");
        @(negedge clk);
        rst = 1'b0;
        apply('{1'b1, CC, 1'b0, 1'b0, 4'd0, 12'h000, 1'b0, 1'b0, 1'b0, 4'd1});
        apply('{1'b0, CC, 1'b1, 1'b1, 4'd0, 12'hFFF, 1'b0, 1'b0, 1'b0, 4'd1});
        check(1'b0, 1'b0, 1, "counter cleared by reset R1");
        apply('{1'b0, CC, 1'b1, 1'b1, 4'd0, 12'hFFF, 1'b0, 1'b1, 1'b1, 4'd5});
        check(1'b1, 1'b1, 5, "run of two after reset R5");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule